// File: doc/BRIEF.md
# Dual-Channel Parallel ADC Read Controller

This block sits on the host side of a converter that holds two 14-bit successive-approximation channels and returns both results over one parallel bus. A single start request latches the requested input pair onto the pair-select line and drives the active-low convert strobe. It then watches the converter's busy flag rise and fall, and makes two chip-select/read cycles. The first cycle returns input 1 of the chosen pair and the second returns input 2. The two words come out together with a one-cycle valid strobe.

Each interface minimum is a parameter given in system clock cycles and rounded up: the convert strobe width, the read strobe width, the data access delay, the gap between reads, and the quiet time before the next conversion. A watchdog limits how long the controller waits on the busy flag. A compile-time switch chooses between two output codings. Bipolar ranges use two's complement and are sign-extended. The unipolar range uses straight binary and is zero-extended.

Top module: `twin_adc_reader`

## Requirements
- R1: While reset is applied and after it is released, `adc_cnv_n_o`, `adc_cs_n_o` and `adc_rd_n_o` are high and `words_valid_o`, `seq_busy_o` and `timeout_o` are low.
- R2: The value of `pair_sel_i` (0 = pair A, 1 = pair B) at the accepted start appears on `adc_pair_o` before `adc_cnv_n_o` falls. It holds steady until `seq_busy_o` drops.
- R3: Every low pulse on `adc_cnv_n_o` lasts exactly `CNV_LOW_CYC` cycles.
- R4: Reads start only after the synchronized busy flag has gone high and then low. `adc_rd_n_o` is low only while `adc_cs_n_o` is low, and neither is low while `adc_cnv_n_o` is low.
- R5: Each conversion makes exactly two read strobes. Each is low for `max(RD_LOW_CYC, ACCESS_CYC)` cycles, and they are separated by `RD_GAP_CYC` cycles with `adc_rd_n_o` high and chip select still low.
- R6: The bus is sampled at the clock edge that ends the `ACCESS_CYC`-th low cycle of each read strobe. The first read goes to `word1_o` (input 1 of the pair) and the second goes to `word2_o` (input 2).
- R7: `words_valid_o` is a single-cycle pulse, one per completed conversion, and the words are valid while it is high.
- R8: With `BIPOLAR`=1 the 14-bit word is treated as two's complement and bit 13 is copied into the upper output bits. With `BIPOLAR`=0 the upper bits are zero.
- R9: After the second read strobe rises, at least `QUIET_CYC` cycles pass before `adc_cnv_n_o` falls again.
- R10: A start request while `seq_busy_o` is high (conversion, reads or quiet time) starts nothing and does not change the pair of the running sequence.
- R11: If busy has not risen and fallen within `TIMEOUT_CYC` cycles of the convert strobe falling, `timeout_o` pulses once, no read is made, no valid is raised, and the controller returns to idle after the quiet time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion and two reads |
| pair_sel_i | input | 1 | Input pair to convert, 0 = A, 1 = B |
| adc_busy_i | input | 1 | Converter busy flag (asynchronous) |
| adc_data_i | input | DATA_W | Converter parallel data bus |
| adc_cnv_n_o | output | 1 | Active-low convert strobe |
| adc_pair_o | output | 1 | Pair select line to the converter |
| adc_cs_n_o | output | 1 | Active-low chip select |
| adc_rd_n_o | output | 1 | Active-low read strobe |
| word1_o | output | OUT_W | Result for input 1 of the pair, formatted |
| word2_o | output | OUT_W | Result for input 2 of the pair, formatted |
| words_valid_o | output | 1 | One-cycle strobe, both words valid |
| seq_busy_o | output | 1 | A sequence or its quiet time is in progress; starts are ignored |
| timeout_o | output | 1 | One-cycle pulse when the busy handshake timed out |

## Verification
The bench exercises conversions on pair A with positive words and on pair B with words that have bit 13 set. Two instances, one per coding, read the same bus, so sign extension is checked against zero extension. Boundary words 0x1FFF and 0x2000 show where the two codings diverge. The converter model presents correct data only during the access cycle and presents the complement at all other times, so a sample point one cycle early or late shows up as a wrong word. Four further patterns are covered. A pair change just after start and a start in mid-sequence show that the selection is latched and that overlapping requests are dropped. A start held high separates the quiet-time gap from the idle path. A converter that never raises busy exercises the timeout path and the recovery after it.

// File: rtl/twin_adc_pkg.sv
`timescale 1ns/1ps
package twin_adc_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CNV,
        ST_WAIT_HI,
        ST_WAIT_LO,
        ST_RD1,
        ST_GAP,
        ST_RD2,
        ST_QUIET
    } seq_state_e;
endpackage

// File: rtl/twin_cycle_timer.sv
`timescale 1ns/1ps
module twin_cycle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i - CNT_W'(1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
    assign done_o  = (cnt_q == '0);
endmodule

// File: rtl/twin_conv_watchdog.sv
`timescale 1ns/1ps
module twin_conv_watchdog #(
    parameter int LIMIT = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    output logic expired_o
);
    localparam int WD_W = $clog2(LIMIT + 1);

    logic [WD_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!arm_i)
            cnt_d = '0;
        else if (cnt_q != WD_W'(LIMIT))
            cnt_d = cnt_q + WD_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == WD_W'(LIMIT));

    // R11: the count only climbs while armed and never passes the limit
    p_wd_bounded_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |=> cnt_q == '0);
endmodule

// File: rtl/twin_word_fmt.sv
`timescale 1ns/1ps
module twin_word_fmt #(
    parameter int IN_W    = 14,
    parameter int OUT_W   = 16,
    parameter bit BIPOLAR = 1'b1
) (
    input  logic [IN_W-1:0]  raw_i,
    output logic [OUT_W-1:0] word_o
);
    localparam int EXT_W = OUT_W - IN_W;

    generate
        if (EXT_W == 0) begin : g_plain
            assign word_o = raw_i;
        end else if (BIPOLAR) begin : g_sign
            assign word_o = {{EXT_W{raw_i[IN_W-1]}}, raw_i};
        end else begin : g_zero
            assign word_o = {{EXT_W{1'b0}}, raw_i};
        end
    endgenerate
endmodule

// File: rtl/twin_adc_reader.sv
`timescale 1ns/1ps
module twin_adc_reader
    import twin_adc_pkg::*;
#(
    parameter int DATA_W      = 14,
    parameter int OUT_W       = 16,
    parameter bit BIPOLAR     = 1'b1,
    parameter int CNV_LOW_CYC = 9,
    parameter int RD_LOW_CYC  = 12,
    parameter int ACCESS_CYC  = 8,
    parameter int RD_GAP_CYC  = 3,
    parameter int QUIET_CYC   = 100,
    parameter int TIMEOUT_CYC = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              pair_sel_i,
    input  logic              adc_busy_i,
    input  logic [DATA_W-1:0] adc_data_i,
    output logic              adc_cnv_n_o,
    output logic              adc_pair_o,
    output logic              adc_cs_n_o,
    output logic              adc_rd_n_o,
    output logic [OUT_W-1:0]  word1_o,
    output logic [OUT_W-1:0]  word2_o,
    output logic              words_valid_o,
    output logic              seq_busy_o,
    output logic              timeout_o
);
    localparam int RD_HOLD_CYC = (RD_LOW_CYC > ACCESS_CYC) ? RD_LOW_CYC : ACCESS_CYC;
    localparam int MAX_A       = (CNV_LOW_CYC > RD_HOLD_CYC) ? CNV_LOW_CYC : RD_HOLD_CYC;
    localparam int MAX_B       = (RD_GAP_CYC > QUIET_CYC) ? RD_GAP_CYC : QUIET_CYC;
    localparam int TMR_MAX     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TMR_W       = $clog2(TMR_MAX + 1);
    localparam int SAMPLE_AT   = RD_HOLD_CYC - ACCESS_CYC;
    localparam int N_WORDS     = 2;

    typedef struct packed {
        seq_state_e        st;
        logic [1:0]        bsy_sync;
        logic              pair;
        logic              cnv_n;
        logic              cs_n;
        logic              rd_n;
        logic [DATA_W-1:0] w0;
        logic [DATA_W-1:0] w1;
        logic              vld;
        logic              tmo;
        logic              busy;
    } regs_t;

    regs_t r_d, r_q;

    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic [TMR_W-1:0] tmr_count;
    logic             tmr_done;
    logic             wd_arm;
    logic             wd_expired;
    logic             busy_s;
    logic             sample_now;

    twin_cycle_timer #(.CNT_W(TMR_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .count_o    (tmr_count),
        .done_o     (tmr_done)
    );

    assign wd_arm = (r_q.st == ST_CNV) || (r_q.st == ST_WAIT_HI) || (r_q.st == ST_WAIT_LO);

    twin_conv_watchdog #(.LIMIT(TIMEOUT_CYC)) u_watchdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (wd_arm),
        .expired_o (wd_expired)
    );

    assign busy_s     = r_q.bsy_sync[1];
    assign sample_now = (tmr_count == TMR_W'(SAMPLE_AT));

    always_comb begin
        r_d          = r_q;
        r_d.vld      = 1'b0;
        r_d.tmo      = 1'b0;
        r_d.bsy_sync = {r_q.bsy_sync[0], adc_busy_i};
        tmr_load     = 1'b0;
        tmr_val      = '0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st   = ST_SETUP;
                    r_d.pair = pair_sel_i;
                end
            end
            ST_SETUP: begin
                r_d.st   = ST_CNV;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(CNV_LOW_CYC);
            end
            ST_CNV: begin
                if (tmr_done) r_d.st = ST_WAIT_HI;
            end
            ST_WAIT_HI: begin
                if (wd_expired) begin
                    r_d.st   = ST_QUIET;
                    r_d.tmo  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(QUIET_CYC);
                end else if (busy_s) begin
                    r_d.st = ST_WAIT_LO;
                end
            end
            ST_WAIT_LO: begin
                if (wd_expired) begin
                    r_d.st   = ST_QUIET;
                    r_d.tmo  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(QUIET_CYC);
                end else if (!busy_s) begin
                    r_d.st   = ST_RD1;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(RD_HOLD_CYC);
                end
            end
            ST_RD1: begin
                if (sample_now) r_d.w0 = adc_data_i;
                if (tmr_done) begin
                    r_d.st   = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(RD_GAP_CYC);
                end
            end
            ST_GAP: begin
                if (tmr_done) begin
                    r_d.st   = ST_RD2;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(RD_HOLD_CYC);
                end
            end
            ST_RD2: begin
                if (sample_now) begin
                    r_d.w1  = adc_data_i;
                    r_d.vld = 1'b1;
                end
                if (tmr_done) begin
                    r_d.st   = ST_QUIET;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(QUIET_CYC);
                end
            end
            ST_QUIET: begin
                if (tmr_done) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase

        r_d.cnv_n = (r_d.st != ST_CNV);
        r_d.rd_n  = !((r_d.st == ST_RD1) || (r_d.st == ST_RD2));
        r_d.cs_n  = !((r_d.st == ST_RD1) || (r_d.st == ST_GAP) || (r_d.st == ST_RD2));
        r_d.busy  = (r_d.st != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.st       <= ST_IDLE;
            r_q.cnv_n    <= 1'b1;
            r_q.cs_n     <= 1'b1;
            r_q.rd_n     <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    logic [DATA_W-1:0] raw_w [N_WORDS];
    logic [OUT_W-1:0]  fmt_w [N_WORDS];

    assign raw_w[0] = r_q.w0;
    assign raw_w[1] = r_q.w1;

    generate
        for (genvar g = 0; g < N_WORDS; g++) begin : g_fmt
            twin_word_fmt #(
                .IN_W    (DATA_W),
                .OUT_W   (OUT_W),
                .BIPOLAR (BIPOLAR)
            ) u_fmt (
                .raw_i  (raw_w[g]),
                .word_o (fmt_w[g])
            );
        end
    endgenerate

    assign adc_cnv_n_o   = r_q.cnv_n;
    assign adc_pair_o    = r_q.pair;
    assign adc_cs_n_o    = r_q.cs_n;
    assign adc_rd_n_o    = r_q.rd_n;
    assign word1_o       = fmt_w[0];
    assign word2_o       = fmt_w[1];
    assign words_valid_o = r_q.vld;
    assign seq_busy_o    = r_q.busy;
    assign timeout_o     = r_q.tmo;

    // Width counters for the pulse checks
    logic [TMR_W-1:0] chk_cnv_len, chk_rd_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_cnv_len <= '0;
            chk_rd_len  <= '0;
        end else begin
            chk_cnv_len <= adc_cnv_n_o ? '0 : chk_cnv_len + TMR_W'(1);
            chk_rd_len  <= adc_rd_n_o  ? '0 : chk_rd_len  + TMR_W'(1);
        end
    end

    p_pair_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy_o && $past(seq_busy_o) |-> $stable(adc_pair_o));

    p_cnv_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_cnv_n_o) |-> chk_cnv_len == TMR_W'(CNV_LOW_CYC));

    p_rd_in_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_rd_n_o |-> !adc_cs_n_o);

    p_no_cs_in_cnv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_cnv_n_o |-> adc_cs_n_o);

    p_read_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n_o) |-> !$past(busy_s));

    p_rd_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_rd_n_o) |-> chk_rd_len == TMR_W'(RD_HOLD_CYC));

    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        words_valid_o |=> !words_valid_o);

    p_timeout_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> adc_cs_n_o && !words_valid_o);
endmodule

// File: tb/twin_adc_reader_bench.sv
`timescale 1ns/1ps
module twin_adc_reader_bench;
    localparam int DW      = 14;
    localparam int OW      = 16;
    localparam int CNV_C   = 9;
    localparam int RDL_C   = 12;
    localparam int ACC_C   = 8;
    localparam int GAP_C   = 3;
    localparam int QUI_C   = 100;
    localparam int TMO_C   = 400;
    localparam int CONV_C  = 150;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic sel = 1'b0;
    logic adc_busy = 1'b0;
    logic [DW-1:0] adc_data = '0;

    logic cnv_n, pair, cs_n, rd_n, vld, sbusy, tmo;
    logic [OW-1:0] w1, w2;
    logic cnv_n_u, pair_u, cs_n_u, rd_n_u, vld_u, sbusy_u, tmo_u;
    logic [OW-1:0] w1_u, w2_u;

    always #2 clk = ~clk;

    twin_adc_reader #(
        .DATA_W(DW), .OUT_W(OW), .BIPOLAR(1'b1), .CNV_LOW_CYC(CNV_C),
        .RD_LOW_CYC(RDL_C), .ACCESS_CYC(ACC_C), .RD_GAP_CYC(GAP_C),
        .QUIET_CYC(QUI_C), .TIMEOUT_CYC(TMO_C)
    ) u_twin_adc_reader (
        .clk(clk), .rst_n(rst_n), .start_i(start), .pair_sel_i(sel),
        .adc_busy_i(adc_busy), .adc_data_i(adc_data),
        .adc_cnv_n_o(cnv_n), .adc_pair_o(pair), .adc_cs_n_o(cs_n), .adc_rd_n_o(rd_n),
        .word1_o(w1), .word2_o(w2), .words_valid_o(vld), .seq_busy_o(sbusy), .timeout_o(tmo)
    );

    twin_adc_reader #(
        .DATA_W(DW), .OUT_W(OW), .BIPOLAR(1'b0), .CNV_LOW_CYC(CNV_C),
        .RD_LOW_CYC(RDL_C), .ACCESS_CYC(ACC_C), .RD_GAP_CYC(GAP_C),
        .QUIET_CYC(QUI_C), .TIMEOUT_CYC(TMO_C)
    ) u_twin_adc_reader_uni (
        .clk(clk), .rst_n(rst_n), .start_i(start), .pair_sel_i(sel),
        .adc_busy_i(adc_busy), .adc_data_i(adc_data),
        .adc_cnv_n_o(cnv_n_u), .adc_pair_o(pair_u), .adc_cs_n_o(cs_n_u), .adc_rd_n_o(rd_n_u),
        .word1_o(w1_u), .word2_o(w2_u), .words_valid_o(vld_u), .seq_busy_o(sbusy_u), .timeout_o(tmo_u)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_ge(input string req, input int act, input int lim);
        n_chk++;
        if (act < lim) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected at least %0d", req, act, lim);
        end
    endtask

    // Converter model and interface monitor
    logic [DW-1:0] va1, va2, vb1, vb2;
    logic stall = 1'b0;
    logic cnv_prev = 1'b1, rd_prev = 1'b1;
    int cnv_len = 0, rd_len = 0, gap_len = 0, q_cnt = 0;
    int last_cnv_w = 0, last_gap = 0, last_quiet = 0, rd_idx = 0;
    int rd_w [2];
    int cnv_falls = 0, rd_falls = 0, valid_cnt = 0, tmo_cnt = 0;
    int bad_cs = 0, early_rd = 0, pair_moves = 0;
    logic mux_at_cnv = 1'b0, have_rd = 1'b0, pair_prev = 1'b0, sb_prev = 1'b0;

    function automatic logic [DW-1:0] pick(input logic p, input int idx);
        if (!p) return (idx == 0) ? va1 : va2;
        return (idx == 0) ? vb1 : vb2;
    endfunction

    function automatic logic [OW-1:0] ext(input logic [DW-1:0] v, input logic bip);
        if (bip) return {{(OW-DW){v[DW-1]}}, v};
        return {{(OW-DW){1'b0}}, v};
    endfunction

    initial begin
        forever begin
            @(negedge cnv_n);
            if (!stall) begin
                @(negedge clk);
                adc_busy = 1'b1;
                repeat (CONV_C) @(negedge clk);
                adc_busy = 1'b0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (!cnv_n) begin
                cnv_len++;
                if (cnv_prev) begin
                    cnv_falls++;
                    mux_at_cnv = pair;
                    rd_idx = 0;
                    if (have_rd) last_quiet = q_cnt;
                    have_rd = 1'b0;
                end
            end else if (!cnv_prev) begin
                last_cnv_w = cnv_len;
                cnv_len = 0;
            end
            if (!rd_n) begin
                if (rd_prev) begin
                    rd_falls++;
                    if (rd_idx == 1) last_gap = gap_len;
                    if (adc_busy) early_rd++;
                end
                rd_len++;
                if (cs_n) bad_cs++;
            end else begin
                if (!rd_prev) begin
                    if (rd_idx < 2) rd_w[rd_idx] = rd_len;
                    rd_idx++;
                    have_rd = 1'b1;
                    q_cnt = 0;
                    gap_len = 0;
                end
                rd_len = 0;
                if (!cs_n) gap_len++;
                if (have_rd) q_cnt++;
            end
            if (vld) valid_cnt++;
            if (tmo) tmo_cnt++;
            if (sb_prev && sbusy && pair != pair_prev) pair_moves++;
            adc_data = (rd_len == ACC_C) ? pick(mux_at_cnv, rd_idx) : ~pick(mux_at_cnv, rd_idx);
            cnv_prev = cnv_n;
            rd_prev = rd_n;
            pair_prev = pair;
            sb_prev = sbusy;
        end
    end

    task automatic pulse_start(input logic s);
        @(negedge clk);
        start = 1'b1;
        sel = s;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (sbusy && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // One full conversion; checks words, timing and the single valid pulse
    task automatic t_convert(input string tag, input logic s, input logic flip_sel);
        logic [DW-1:0] e1, e2;
        int guard = 0;
        int v0 = valid_cnt;
        int c0 = cnv_falls;
        int r0 = rd_falls;
        logic got = 1'b0;
        e1 = pick(s, 0);
        e2 = pick(s, 1);
        pulse_start(s);
        if (flip_sel) sel = ~s;
        while (!got && guard < 2000) begin
            @(negedge clk);
            guard++;
            if (vld) begin
                got = 1'b1;
                chk({tag, " R6 word1 bipolar / R8"}, 32'(w1), 32'(ext(e1, 1'b1)));
                chk({tag, " R6 word2 bipolar / R8"}, 32'(w2), 32'(ext(e2, 1'b1)));
                chk({tag, " R8 word1 unipolar"}, 32'(w1_u), 32'(ext(e1, 1'b0)));
                chk({tag, " R8 word2 unipolar"}, 32'(w2_u), 32'(ext(e2, 1'b0)));
            end
        end
        chk({tag, " R7 valid seen"}, 32'(got), 32'd1);
        wait_idle();
        chk({tag, " R2 pair line"}, 32'(mux_at_cnv), 32'(s));
        chk({tag, " R2 pair steady"}, 32'(pair_moves), 32'd0);
        chk({tag, " R3 convert width"}, 32'(last_cnv_w), 32'(CNV_C));
        chk({tag, " R5 read1 width"}, 32'(rd_w[0]), 32'(RDL_C));
        chk({tag, " R5 read2 width"}, 32'(rd_w[1]), 32'(RDL_C));
        chk({tag, " R5 read gap"}, 32'(last_gap), 32'(GAP_C));
        chk({tag, " R5 two reads"}, 32'(rd_falls - r0), 32'd2);
        chk({tag, " R7 one valid cycle"}, 32'(valid_cnt - v0), 32'd1);
        chk({tag, " R4 rd within cs"}, 32'(bad_cs), 32'd0);
        chk({tag, " R4 no read while busy"}, 32'(early_rd), 32'd0);
        chk({tag, " R10 one convert"}, 32'(cnv_falls - c0), 32'd1);
    endtask

    task automatic t_reset();
        chk("R1 cnv_n", 32'(cnv_n), 32'd1);
        chk("R1 cs_n", 32'(cs_n), 32'd1);
        chk("R1 rd_n", 32'(rd_n), 32'd1);
        chk("R1 valid", 32'(vld), 32'd0);
        chk("R1 seq_busy", 32'(sbusy), 32'd0);
        chk("R1 timeout", 32'(tmo), 32'd0);
    endtask

    task automatic t_ignore();
        int c0 = cnv_falls;
        logic [DW-1:0] e1 = va1;
        logic [DW-1:0] e2 = va2;
        logic [OW-1:0] g1 = '0;
        logic [OW-1:0] g2 = '0;
        int guard = 0;
        pulse_start(1'b0);
        repeat (40) @(negedge clk);
        chk("R10 busy during sequence", 32'(sbusy), 32'd1);
        pulse_start(1'b1);
        while (!vld && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        g1 = w1;
        g2 = w2;
        chk("R10 pair unchanged word1", 32'(g1), 32'(ext(e1, 1'b1)));
        chk("R10 pair unchanged word2", 32'(g2), 32'(ext(e2, 1'b1)));
        repeat (40) @(negedge clk);
        pulse_start(1'b1);
        wait_idle();
        repeat (30) @(negedge clk);
        chk("R10 no extra convert", 32'(cnv_falls - c0), 32'd1);
        chk("R10 idle after drop", 32'(sbusy), 32'd0);
    endtask

    task automatic t_quiet();
        int v0 = valid_cnt;
        int guard = 0;
        @(negedge clk);
        start = 1'b1;
        sel = 1'b0;
        while ((valid_cnt - v0) < 2 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        start = 1'b0;
        wait_idle();
        chk("R9 back-to-back valids", 32'(valid_cnt - v0), 32'd2);
        chk_ge("R9 quiet gap", last_quiet, QUI_C);
    endtask

    task automatic t_timeout();
        int r0 = rd_falls;
        int v0 = valid_cnt;
        int t0 = tmo_cnt;
        stall = 1'b1;
        pulse_start(1'b1);
        repeat (TMO_C + 40) @(negedge clk);
        wait_idle();
        chk("R11 timeout pulse", 32'(tmo_cnt - t0), 32'd1);
        chk("R11 no reads", 32'(rd_falls - r0), 32'd0);
        chk("R11 no valid", 32'(valid_cnt - v0), 32'd0);
        chk("R11 back to idle", 32'(sbusy), 32'd0);
        stall = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        va1 = 14'h0123; va2 = 14'h1ABC; vb1 = 14'h2001; vb2 = 14'h3FFF;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_convert("pairA", 1'b0, 1'b0);
        t_convert("pairB", 1'b1, 1'b0);
        va1 = 14'h1FFF; va2 = 14'h2000;
        t_convert("edges", 1'b0, 1'b1);
        t_ignore();
        t_quiet();
        t_timeout();
        vb1 = 14'h0555; vb2 = 14'h2AAA;
        t_convert("recover", 1'b1, 1'b0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule